// File: doc/BRIEF.md
# Carrier-Comparison Space Vector PWM Generator

This block produces the six gate commands of a two-level three-phase bridge from three signed phase references. No sector decode and no dwell-time arithmetic are used. Each reference is multiplied by a fixed gain of about 1.156. A common-mode term is then subtracted from all three scaled values. That term is the midpoint between the largest and the smallest scaled value. Each shifted reference is then compared against a symmetric triangular carrier. The result is the same centred switching pattern that a space vector modulator produces.

The carrier is an internal up/down counter. Its peak value P comes from a period input, so one carrier cycle lasts 2·P clocks. References are signed counts around the carrier midpoint, and ±P/2 is the linear range. The references and the peak are captured together once per carrier cycle, at the carrier top. A controller can therefore update them at any time without tearing a cycle. Dead time is added downstream.

Top module: `svpwm_gen`

## Requirements
- R1: While rst_ni is low, all six gate outputs are low. They stay low through the first clock edge after release. They become valid from the second edge onward.
- R2: The carrier visits the value P once, then P-1 down to 1, then 0 once, then 1 up to P-1, so one cycle lasts 2·P clocks. P is the period input captured at the carrier top. A period input below 2 is treated as 2.
- R3: Each reference r is scaled to s = floor(r·18940 / 2^14).
- R4: The offset is cm = floor((max(s) + min(s)) / 2), and each phase uses m = s − cm.
- R5: An upper gate is high while c = m + ceil(P/2) is strictly greater than the carrier. Over one carrier cycle it is therefore high for 0 clocks if c ≤ 0, for 2·P clocks if c > P, and for 2·c − 1 clocks otherwise.
- R6: Once valid, each lower gate is the exact complement of the upper gate of its own leg. Bit 0 is phase a, bit 1 is phase b and bit 2 is phase c on both gate buses.
- R7: References and period are sampled only at the carrier top. A change between two tops has no effect on the outputs until one clock after the next top.
- R8: The upper gate states are nested by c. Whenever a leg is high, every leg with an equal or larger c is also high. The states therefore step through the 000, 100, 110, 111, 111, 110, 100, 000 pattern, in the order set by the phases.
- R9: With references inside the linear range, the total 000 time and the total 111 time in one carrier cycle differ by no more than 2 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_a_i | input | REF_W | Phase a reference, signed counts around the carrier midpoint |
| ref_b_i | input | REF_W | Phase b reference |
| ref_c_i | input | REF_W | Phase c reference |
| period_i | input | CNT_W | Carrier peak value P |
| gate_hi_o | output | 3 | Upper switch commands, bit k = phase k |
| gate_lo_o | output | 3 | Lower switch commands, bit k = phase k |

## Verification
Two things happen in the same clock at the carrier top. The carrier turns around, and the comparators load new compare values while they are still evaluating the old ones. The bench locks onto the known position of the top. It records a full cycle of gate states, then changes the references halfway through the next cycle. Every state up to and including the top clock must match the recorded cycle. The cycle after that must show the duty that R5 predicts for the new values.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;
  localparam int NUM_PH = 3;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} ramp_dir_e;
endpackage

// File: rtl/svpwm_carrier.sv
module svpwm_carrier import svpwm_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] eff_o,
  output logic             top_o
);
  logic [CNT_W-1:0] cnt_q, peak_q;
  ramp_dir_e        dir_q;

  assign eff_o = (period_i < CNT_W'(2)) ? CNT_W'(2) : period_i;
  assign top_o = (dir_q == DIR_UP) && (cnt_q == peak_q);
  assign cnt_o = cnt_q;

  // out of reset the first clock is a top, which captures the first period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      peak_q <= '0;
      dir_q  <= DIR_UP;
    end else if (top_o) begin
      peak_q <= eff_o;
      cnt_q  <= eff_o - CNT_W'(1);
      dir_q  <= DIR_DOWN;
    end else if (dir_q == DIR_UP) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (cnt_q == '0) begin
      cnt_q <= CNT_W'(1);
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= peak_q);
  a_r2_rising_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q == DIR_UP) && !top_o |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  a_r2_peak_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_o |=> peak_q >= CNT_W'(2));
endmodule

// File: rtl/svpwm_offset.sv
module svpwm_offset import svpwm_pkg::*; #(
  parameter int REF_W     = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_Q    = 18940,
  parameter int GAIN_FRAC = 14,
  parameter int MW        = REF_W + GAIN_W + 2 - GAIN_FRAC
) (
  input  logic [NUM_PH-1:0][REF_W-1:0] ref_i,
  output logic [NUM_PH-1:0][MW-1:0]    m_o
);
  localparam int PW = REF_W + GAIN_W + 1;
  localparam int SW = PW - GAIN_FRAC;
  localparam logic signed [GAIN_W:0] GAIN_S = (GAIN_W + 1)'(GAIN_Q);

  logic signed [SW-1:0] s [NUM_PH];
  logic signed [SW-1:0] s_max, s_min;
  logic signed [SW:0]   ext_sum, cm;

  for (genvar k = 0; k < NUM_PH; k++) begin : g_scale
    logic signed [PW-1:0] prod;
    assign prod = $signed(ref_i[k]) * GAIN_S;
    assign s[k] = SW'(prod >>> GAIN_FRAC);
  end

  always_comb begin
    s_max = s[0];
    s_min = s[0];
    for (int k = 1; k < NUM_PH; k++) begin
      if (s[k] > s_max) s_max = s[k];
      if (s[k] < s_min) s_min = s[k];
    end
  end

  assign ext_sum = (SW + 1)'(s_max) + (SW + 1)'(s_min);
  assign cm      = ext_sum >>> 1;

  for (genvar k = 0; k < NUM_PH; k++) begin : g_shift
    logic signed [SW:0] diff;
    assign diff   = (SW + 1)'(s[k]) - cm;
    assign m_o[k] = MW'(diff);
  end
endmodule

// File: rtl/svpwm_leg.sv
module svpwm_leg #(
  parameter int CW    = 20,
  parameter int CNT_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic signed [CW-1:0] cmp_d_i,
  input  logic                 valid_i,
  input  logic [CNT_W-1:0]     cnt_i,
  output logic                 gate_hi_o,
  output logic                 gate_lo_o
);
  logic signed [CW-1:0] cmp_q, cnt_ext;
  logic                 above;

  assign cnt_ext = $signed({{(CW - CNT_W){1'b0}}, cnt_i});
  assign above   = cmp_q > cnt_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q     <= '0;
      gate_hi_o <= 1'b0;
      gate_lo_o <= 1'b0;
    end else begin
      if (load_i) cmp_q <= cmp_d_i;
      gate_hi_o <= valid_i & above;
      gate_lo_o <= valid_i & ~above;
    end
  end

  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !gate_hi_o && !gate_lo_o);
  a_r6_pair_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> gate_hi_o != gate_lo_o);
  a_r7_hold_between_tops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cmp_q));
endmodule

// File: rtl/svpwm_gen.sv
module svpwm_gen import svpwm_pkg::*; #(
  parameter int REF_W     = 16,
  parameter int CNT_W     = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_Q    = 18940,
  parameter int GAIN_FRAC = 14
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [REF_W-1:0] ref_a_i,
  input  logic signed [REF_W-1:0] ref_b_i,
  input  logic signed [REF_W-1:0] ref_c_i,
  input  logic [CNT_W-1:0]        period_i,
  output logic [NUM_PH-1:0]       gate_hi_o,
  output logic [NUM_PH-1:0]       gate_lo_o
);
  localparam int MW = REF_W + GAIN_W + 2 - GAIN_FRAC;
  localparam int CW = ((MW > CNT_W + 1) ? MW : CNT_W + 1) + 1;

  logic [CNT_W-1:0]              cnt, eff;
  logic                          top, valid_q;
  logic [CNT_W:0]                half;
  logic [NUM_PH-1:0][REF_W-1:0]  refs;
  logic [NUM_PH-1:0][MW-1:0]     m;

  assign refs = {ref_c_i, ref_b_i, ref_a_i};
  assign half = ({1'b0, eff} + (CNT_W + 1)'(1)) >> 1;

  svpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk_i, .rst_ni, .period_i,
    .cnt_o(cnt), .eff_o(eff), .top_o(top)
  );

  svpwm_offset #(
    .REF_W(REF_W), .GAIN_W(GAIN_W), .GAIN_Q(GAIN_Q),
    .GAIN_FRAC(GAIN_FRAC), .MW(MW)
  ) u_offset (.ref_i(refs), .m_o(m));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  valid_q <= 1'b0;
    else if (top) valid_q <= 1'b1;
  end

  for (genvar k = 0; k < NUM_PH; k++) begin : g_leg
    logic signed [CW-1:0] cmp_d;
    assign cmp_d = CW'($signed(m[k])) + $signed(CW'(half));
    svpwm_leg #(.CW(CW), .CNT_W(CNT_W)) u_leg (
      .clk_i, .rst_ni,
      .load_i(top), .cmp_d_i(cmp_d), .valid_i(valid_q), .cnt_i(cnt),
      .gate_hi_o(gate_hi_o[k]), .gate_lo_o(gate_lo_o[k])
    );
  end

  a_r1_valid_after_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q && !top |=> !valid_q);
endmodule

// File: tb/svpwm_gen_bench.sv
module svpwm_gen_bench;
  localparam int CLK_NS = 10;
  localparam int P_B    = 200;
  localparam int W      = 2 * P_B;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic signed [15:0] ra = '0, rb = '0, rc = '0;
  logic [15:0] period = 16'(P_B);
  logic [2:0] hi, lo;
  int n_chk = 0, n_fail = 0, edge_n = 0;
  bit done = 1'b0;

  svpwm_gen u_svpwm_gen (
    .clk_i(clk), .rst_ni(rst_ni), .ref_a_i(ra), .ref_b_i(rb), .ref_c_i(rc),
    .period_i(period), .gate_hi_o(hi), .gate_lo_o(lo)
  );

  always #(CLK_NS / 2) clk = ~clk;
  always @(posedge clk) if (rst_ni) edge_n <= edge_n + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic longint scaled(longint r);
    return (r * 18940) >>> 14;
  endfunction

  function automatic longint exp_c(longint a, longint b, longint c, int idx, longint p);
    longint s[3], mx, mn, cm;
    s[0] = scaled(a); s[1] = scaled(b); s[2] = scaled(c);
    mx = s[0]; mn = s[0];
    for (int k = 1; k < 3; k++) begin
      if (s[k] > mx) mx = s[k];
      if (s[k] < mn) mn = s[k];
    end
    cm = (mx + mn) >>> 1;
    return s[idx] - cm + ((p + 1) >>> 1);
  endfunction

  function automatic longint exp_hi(longint c, longint p);
    if (c <= 0) return 0;
    if (c > p) return 2 * p;
    return 2 * c - 1;
  endfunction

  // one measurement point; refs held constant, full cycle observed
  task automatic run_point(input int a, input int b, input int c, input bit sym, input string tag);
    longint cv[3];
    int nh[3];
    int n000 = 0, n111 = 0, bad_c = 0, bad_o = 0;
    ra = 16'(a); rb = 16'(b); rc = 16'(c);
    for (int k = 0; k < 3; k++) begin
      cv[k] = exp_c(a, b, c, k, P_B);
      nh[k] = 0;
    end
    repeat (W + 3) step();
    for (int t = 0; t < W; t++) begin
      step();
      for (int k = 0; k < 3; k++) if (hi[k]) nh[k]++;
      if (hi == 3'b000) n000++;
      if (hi == 3'b111) n111++;
      if (lo !== ~hi) bad_c++;
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          if (hi[j] && !hi[i] && cv[i] >= cv[j]) bad_o++;
    end
    for (int k = 0; k < 3; k++)
      check(nh[k] == exp_hi(cv[k], P_B), {"R3 R4 R5 duty ", tag}, nh[k], exp_hi(cv[k], P_B));
    check(bad_c == 0, {"R6 complement ", tag}, bad_c, 0);
    check(bad_o == 0, {"R8 nesting ", tag}, bad_o, 0);
    if (sym) check((n000 - n111 <= 2) && (n111 - n000 <= 2), {"R9 null balance ", tag}, n000 - n111, 0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (4) step();
    check(hi == 3'b000 && lo == 3'b000, "R1 low in reset", {hi, lo}, 0);
    rst_ni = 1'b1;
    #1;
    check(hi == 3'b000 && lo == 3'b000, "R1 low at release", {hi, lo}, 0);
    step();
    check(hi == 3'b000 && lo == 3'b000, "R1 low after first edge", {hi, lo}, 0);
    step();
    check(hi == 3'b000 && lo == 3'b111, "R1 R6 valid on second edge", {hi, lo}, 6'b000111);
  endtask

  task automatic t_sine();
    int amps[3] = '{30, 60, 95};
    int degs[5] = '{0, 37, 100, 200, 290};
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 5; j++) begin
        real th = degs[j] * 3.14159265358979 / 180.0;
        int a = int'(amps[i] * $cos(th));
        int b = int'(amps[i] * $cos(th - 2.0943951023932));
        int c = int'(amps[i] * $cos(th + 2.0943951023932));
        run_point(a, b, c, 1'b1, $sformatf("sine amp %0d deg %0d", amps[i], degs[j]));
      end
  endtask

  task automatic t_edges();
    run_point(-7, 3, 0, 1'b1, "floor rounding");
    run_point(40, -10, -10, 1'b1, "unbalanced");
    run_point(300, 0, -300, 1'b0, "beyond range");
  endtask

  task automatic t_hold();
    logic [2:0] tr [W];
    int mism_p = 0, mism_h = 0;
    int nh[3] = '{0, 0, 0};
    ra = 16'(60); rb = -16'(20); rc = -16'(40);
    repeat (W + 3) step();
    while (((edge_n - 1) % W) != 0) step();
    for (int o = 0; o < W; o++) begin step(); tr[o] = hi; end
    for (int o = 0; o < P_B; o++) begin step(); if (hi !== tr[o]) mism_p++; end
    check(mism_p == 0, "R2 repeats every 2P clocks", mism_p, 0);
    ra = -16'(50); rb = 16'(70); rc = -16'(20);
    for (int o = P_B; o < W; o++) begin step(); if (hi !== tr[o]) mism_h++; end
    check(mism_h == 0, "R7 mid-cycle change ignored up to top", mism_h, 0);
    for (int o = 0; o < W; o++) begin
      step();
      for (int k = 0; k < 3; k++) if (hi[k]) nh[k]++;
    end
    for (int k = 0; k < 3; k++) begin
      longint cx = exp_c(-50, 70, -20, k, P_B);
      check(nh[k] == exp_hi(cx, P_B), "R7 new refs after top", nh[k], exp_hi(cx, P_B));
    end
  endtask

  task automatic t_clamp();
    logic [2:0] tr [8];
    int mism = 0;
    int nh[3] = '{0, 0, 0};
    ra = '0; rb = '0; rc = '0;
    period = '0;
    repeat (W + 20) step();
    for (int o = 0; o < 8; o++) begin step(); tr[o] = hi; end
    for (int o = 0; o < 4; o++) if (tr[o] !== tr[o + 4]) mism++;
    for (int o = 0; o < 8; o++) for (int k = 0; k < 3; k++) if (tr[o][k]) nh[k]++;
    check(mism == 0, "R2 clamped cycle of 4", mism, 0);
    for (int k = 0; k < 3; k++) check(nh[k] == 2, "R2 clamp duty", nh[k], 2);
    period = 16'd7;
    repeat (40) step();
    nh = '{0, 0, 0};
    for (int o = 0; o < 14; o++) begin
      step();
      for (int k = 0; k < 3; k++) if (hi[k]) nh[k]++;
    end
    for (int k = 0; k < 3; k++)
      check(nh[k] == exp_hi(exp_c(0, 0, 0, k, 7), 7), "R2 R5 odd peak", nh[k], exp_hi(exp_c(0, 0, 0, k, 7), 7));
  endtask

  task automatic t_reset_again();
    ra = 16'(90); rb = '0; rc = -16'(90);
    repeat (30) step();
    check((hi | lo) == 3'b111, "R6 active before reset", hi | lo, 7);
    rst_ni = 1'b0;
    #1;
    check(hi == 3'b000 && lo == 3'b000, "R1 async clear", {hi, lo}, 0);
    step();
  endtask

  initial begin
    t_reset();
    t_sine();
    t_edges();
    t_hold();
    t_clamp();
    t_reset_again();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule